// File: doc/BRIEF.md
# Embedded Program and Erase Sequencer

This block is the autonomous engine behind a flash-style memory's command interface. Once the interface hands it a byte-program, a sector-erase or a whole-array erase request, it carries the job through to the end with no host involvement. It times each pulse with an internal counter, reads the affected cells back to verify them, and repeats pulse and verify until the cells match or an iteration limit runs out. An erase always starts with a pre-program pass that drives every byte of the target range to 00h. Only then does it apply erase pulses, sector by sector.

A small behavioural byte array stands in for the cells. Programming can only clear bits: the new byte is the old byte ANDed with the data. Each erase pulse on a sector sets ERASE_STEP more low-order one bits in every byte of that sector, so the sector reaches FFh after ceil(8/ERASE_STEP) pulses. Pulse lengths are parameters counted in clock cycles, and verifying one byte takes one cycle. NSEC and SEC_BYTES must be powers of two. A byte address is {sector, offset}.

The sequencer drives a busy flag, an iteration-limit failure flag and a suspended flag. The command interface uses these to build its polling and toggle status. A sector erase can be suspended, which frees the array for reads, and resumed later from the exact point where it stopped.

Top module: `epe_sequencer`

## Requirements
- R1: While reset is asserted and just after it is released, busy, limit_fail and suspended are 0 and every byte of the array reads FFh.
- R2: The sequencer accepts cmd_op = 2'b01 (program) only when it is idle, meaning neither busy nor suspended. A program that verifies on the first pulse keeps busy high for exactly PROG_CYCLES+1 cycles: the pulse plus one verify cycle. Afterwards the byte holds old AND cmd_data.
- R3: When a verify mismatches, the sequencer pulses again. After MAX_TRIES failed verifies, limit_fail rises after MAX_TRIES*(PROG_CYCLES+1) busy cycles. busy and limit_fail then stay high until reset_cmd, which returns the block to idle. The byte keeps the ANDed value.
- R4: Any command presented while busy is ignored, including while limit_fail is set. The addressed byte is left unchanged.
- R5: Sector erase is cmd_op = 2'b11, and cmd_sectors bit i selects sector i. Every selected sector ends at FFh and every unselected byte is unchanged. Each selected sector costs SEC_BYTES*(PROG_CYCLES+1) cycles of pre-program. It then costs, for each erase iteration, ERASE_CYCLES cycles of pulse plus one verify cycle per byte, up to and including the first mismatching byte.
- R6: Erase iterations are counted against MAX_TRIES per sector. With ERASE_STEP = 4, every sector needs exactly two pulses. A k-sector erase therefore holds busy for k*(SEC_BYTES*(PROG_CYCLES+1) + 2*ERASE_CYCLES + 1 + SEC_BYTES) cycles.
- R7: Chip erase is cmd_op = 2'b10. It erases every sector whatever the value of cmd_sectors, with the same timing as a sector erase that selects all sectors.
- R8: A sector erase with cmd_sectors equal to zero is ignored, and busy stays low.
- R9: During a sector erase, a suspend_req pulse is honoured just before the next pulse would start. At that point busy falls and suspended rises. suspend_req has no effect during a program or a chip erase.
- R10: While suspended, only resume_req is accepted. Resuming continues at the same sector, byte and iteration, so the busy cycles before and after the suspension add up to the uninterrupted erase time.
- R11: rd_data always shows the current content of the byte at rd_addr, combinationally, in every state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 01 program, 10 chip erase, 11 sector erase |
| cmd_addr | input | AW | Byte address for a program |
| cmd_data | input | 8 | Byte to program |
| cmd_sectors | input | NSEC | Sector selection for a sector erase |
| suspend_req | input | 1 | Request to suspend a sector erase |
| resume_req | input | 1 | Request to resume a suspended erase |
| reset_cmd | input | 1 | Clears the iteration-limit failure state |
| rd_addr | input | AW | Read address into the cell array |
| rd_data | output | 8 | Cell content at rd_addr |
| busy | output | 1 | Operation in progress or failed |
| limit_fail | output | 1 | Iteration limit reached without a good verify |
| suspended | output | 1 | Sector erase parked by a suspend |

## Verification
The bench builds the block with four sectors of eight bytes, PROG_CYCLES = 3, ERASE_CYCLES = 5, MAX_TRIES = 3 and ERASE_STEP = 4. With these values a failed program reaches the limit after 12 busy cycles, and every sector needs one failed and one passing erase iteration, so the retry path runs on every erase. A chip erase finishes in 204 cycles, which keeps an exact cycle count of the whole-array pre-program and erase within reach. The small array also lets the bench read back every byte to confirm which sectors an erase touched. Because the totals are exact, a suspend can be checked by adding the busy cycles before and after it.

// File: rtl/epe_pkg.sv
package epe_pkg;

  typedef enum logic [1:0] {
    OPC_NOP  = 2'b00,
    OPC_PROG = 2'b01,
    OPC_CHIP = 2'b10,
    OPC_SECT = 2'b11
  } opc_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PPULSE,
    ST_PVERIFY,
    ST_EPULSE,
    ST_EVERIFY,
    ST_SUSP,
    ST_FAIL
  } st_e;

  typedef enum logic {
    PK_PROG  = 1'b0,
    PK_ERASE = 1'b1
  } pulse_e;

endpackage

// File: rtl/epe_pulse_timer.sv
module epe_pulse_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [TW-1:0] len,
  output logic          done
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (start) begin
      cnt_d = len - TW'(1);
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - TW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  // last cycle of the pulse window
  assign done = act_q && (cnt_q == '0);

endmodule

// File: rtl/epe_cell_array.sv
module epe_cell_array #(
  parameter int NSEC       = 8,
  parameter int SEC_BYTES  = 64,
  parameter int ERASE_STEP = 8,
  localparam int SW = $clog2(NSEC),
  localparam int OW = $clog2(SEC_BYTES),
  localparam int AW = SW + OW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_en,
  input  logic [AW-1:0] prog_addr,
  input  logic [7:0]    prog_data,
  input  logic          ers_en,
  input  logic [SW-1:0] ers_sec,
  input  logic [AW-1:0] va_addr,
  output logic [7:0]    va_data,
  input  logic [AW-1:0] ra_addr,
  output logic [7:0]    ra_data
);

  localparam int NB = NSEC * SEC_BYTES;
  localparam logic [7:0] FILL = 8'((16'd1 << ERASE_STEP) - 16'd1);

  logic [7:0] mem_q [NB];
  logic [7:0] mem_d [NB];
  logic       wr_en;

  assign wr_en = prog_en | ers_en;

  always_comb begin
    for (int i = 0; i < NB; i++) begin
      mem_d[i] = mem_q[i];
      if (prog_en && prog_addr == AW'(i))
        mem_d[i] = mem_q[i] & prog_data;          // bits only clear
      else if (ers_en && ers_sec == SW'(i >> OW))
        mem_d[i] = mem_q[i] | (mem_q[i] << ERASE_STEP) | FILL;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NB; i++) mem_q[i] <= 8'hFF;
    end else if (wr_en) begin
      mem_q <= mem_d;
    end
  end

  assign va_data = mem_q[va_addr];
  assign ra_data = mem_q[ra_addr];

endmodule

// File: rtl/epe_sequencer.sv
module epe_sequencer
  import epe_pkg::*;
#(
  parameter int NSEC         = 8,
  parameter int SEC_BYTES    = 64,
  parameter int PROG_CYCLES  = 6,
  parameter int ERASE_CYCLES = 40,
  parameter int MAX_TRIES    = 8,
  parameter int ERASE_STEP   = 8,
  localparam int SW  = $clog2(NSEC),
  localparam int OW  = $clog2(SEC_BYTES),
  localparam int AW  = SW + OW,
  localparam int TW  = $clog2((PROG_CYCLES > ERASE_CYCLES ? PROG_CYCLES : ERASE_CYCLES) + 1),
  localparam int TRW = $clog2(MAX_TRIES + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [7:0]      cmd_data,
  input  logic [NSEC-1:0] cmd_sectors,
  input  logic            suspend_req,
  input  logic            resume_req,
  input  logic            reset_cmd,
  input  logic [AW-1:0]   rd_addr,
  output logic [7:0]      rd_data,
  output logic            busy,
  output logic            limit_fail,
  output logic            suspended
);

  st_e             st_q, st_d;
  logic [SW-1:0]   sec_q, sec_d;
  logic [OW-1:0]   off_q, off_d;
  logic [7:0]      data_q, data_d;
  logic [TRW-1:0]  tries_q, tries_d;
  logic [NSEC-1:0] mask_q, mask_d;
  logic            ers_q, ers_d;     // current job is an erase
  logic            sect_q, sect_d;   // current job may be suspended
  logic            pend_q, pend_d;
  pulse_e          rkind_q, rkind_d;

  logic            t_start, t_done;
  logic [TW-1:0]   t_len;
  logic            want;
  pulse_e          want_kind;
  logic            prog_en, ers_en;
  logic [7:0]      va_data;
  logic [NSEC-1:0] sel_mask;
  logic [SW:0]     nx_any, nx_first, nx_sel;

  localparam logic [OW-1:0]  OFF_LAST  = OW'(SEC_BYTES - 1);
  localparam logic [TRW-1:0] TRY_LAST  = TRW'(MAX_TRIES - 1);

  // lowest selected sector strictly above 'from'; top bit flags a hit
  function automatic logic [SW:0] next_sec(input logic [NSEC-1:0] m, input int from);
    logic [SW:0] r;
    r = '0;
    for (int i = NSEC - 1; i >= 0; i--)
      if (m[i] && i > from) r = {1'b1, SW'(i)};
    return r;
  endfunction

  assign sel_mask = (cmd_op == OPC_CHIP) ? '1 : cmd_sectors;
  assign nx_sel   = next_sec(sel_mask, -1);
  assign nx_any   = next_sec(mask_q, int'(sec_q));
  assign nx_first = next_sec(mask_q, -1);

  always_comb begin
    st_d = st_q;  sec_d = sec_q;  off_d = off_q;  data_d = data_q;
    tries_d = tries_q;  mask_d = mask_q;  ers_d = ers_q;  sect_d = sect_q;
    rkind_d = rkind_q;
    pend_d = pend_q;
    want = 1'b0;  want_kind = PK_PROG;
    t_start = 1'b0;  t_len = TW'(PROG_CYCLES);
    prog_en = 1'b0;  ers_en = 1'b0;

    if (suspend_req && sect_q && st_q inside {ST_PPULSE, ST_PVERIFY, ST_EPULSE, ST_EVERIFY})
      pend_d = 1'b1;

    unique case (st_q)
      ST_IDLE: begin
        pend_d = 1'b0;
        if (cmd_valid && cmd_op == OPC_PROG) begin
          {sec_d, off_d} = cmd_addr;
          data_d = cmd_data;  tries_d = '0;  ers_d = 1'b0;  sect_d = 1'b0;
          want = 1'b1;
        end else if (cmd_valid && cmd_op != OPC_NOP && nx_sel[SW]) begin
          mask_d = sel_mask;  sec_d = nx_sel[SW-1:0];  off_d = '0;
          data_d = 8'h00;  tries_d = '0;  ers_d = 1'b1;
          sect_d = (cmd_op == OPC_SECT);
          want = 1'b1;
        end
      end
      ST_PPULSE: begin
        if (t_done) begin
          prog_en = 1'b1;
          st_d = ST_PVERIFY;
        end
      end
      ST_PVERIFY: begin
        if (va_data == data_q) begin
          tries_d = '0;
          if (!ers_q) st_d = ST_IDLE;
          else if (off_q != OFF_LAST) begin
            off_d = off_q + OW'(1);  want = 1'b1;
          end else begin
            off_d = '0;  want = 1'b1;
            if (nx_any[SW]) sec_d = nx_any[SW-1:0];
            else begin
              sec_d = nx_first[SW-1:0];  want_kind = PK_ERASE;
            end
          end
        end else if (tries_q == TRY_LAST) st_d = ST_FAIL;
        else begin
          tries_d = tries_q + TRW'(1);  want = 1'b1;
        end
      end
      ST_EPULSE: begin
        if (t_done) begin
          ers_en = 1'b1;  off_d = '0;
          st_d = ST_EVERIFY;
        end
      end
      ST_EVERIFY: begin
        if (va_data == 8'hFF) begin
          if (off_q != OFF_LAST) off_d = off_q + OW'(1);
          else begin
            tries_d = '0;  off_d = '0;
            if (nx_any[SW]) begin
              sec_d = nx_any[SW-1:0];  want = 1'b1;  want_kind = PK_ERASE;
            end else st_d = ST_IDLE;
          end
        end else if (tries_q == TRY_LAST) st_d = ST_FAIL;
        else begin
          tries_d = tries_q + TRW'(1);  off_d = '0;
          want = 1'b1;  want_kind = PK_ERASE;
        end
      end
      ST_SUSP: begin
        if (resume_req) begin
          st_d = (rkind_q == PK_ERASE) ? ST_EPULSE : ST_PPULSE;
          t_start = 1'b1;
          t_len = (rkind_q == PK_ERASE) ? TW'(ERASE_CYCLES) : TW'(PROG_CYCLES);
        end
      end
      ST_FAIL: begin
        if (reset_cmd) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase

    // a new pulse is the only safe point for a pending suspend
    if (want) begin
      if (pend_d && sect_d) begin
        st_d = ST_SUSP;  rkind_d = want_kind;  pend_d = 1'b0;
      end else begin
        st_d = (want_kind == PK_ERASE) ? ST_EPULSE : ST_PPULSE;
        t_start = 1'b1;
        t_len = (want_kind == PK_ERASE) ? TW'(ERASE_CYCLES) : TW'(PROG_CYCLES);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  sec_q <= '0;  off_q <= '0;  data_q <= '0;
      tries_q <= '0;  mask_q <= '0;  ers_q <= 1'b0;  sect_q <= 1'b0;
      pend_q <= 1'b0;  rkind_q <= PK_PROG;
    end else begin
      st_q <= st_d;  sec_q <= sec_d;  off_q <= off_d;  data_q <= data_d;
      tries_q <= tries_d;  mask_q <= mask_d;  ers_q <= ers_d;  sect_q <= sect_d;
      pend_q <= pend_d;  rkind_q <= rkind_d;
    end
  end

  epe_pulse_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(t_start), .len(t_len), .done(t_done)
  );

  epe_cell_array #(.NSEC(NSEC), .SEC_BYTES(SEC_BYTES), .ERASE_STEP(ERASE_STEP)) u_cells (
    .clk(clk), .rst_n(rst_n),
    .prog_en(prog_en), .prog_addr({sec_q, off_q}), .prog_data(data_q),
    .ers_en(ers_en), .ers_sec(sec_q),
    .va_addr({sec_q, off_q}), .va_data(va_data),
    .ra_addr(rd_addr), .ra_data(rd_data)
  );

  assign busy       = (st_q != ST_IDLE) && (st_q != ST_SUSP);
  assign limit_fail = (st_q == ST_FAIL);
  assign suspended  = (st_q == ST_SUSP);

endmodule

// File: rtl/epe_sequencer_checker.sv
module epe_sequencer_checker #(
  parameter int MAX_TRIES = 8,
  parameter int TRW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cmd_valid,
  input logic           resume_req,
  input logic           reset_cmd,
  input logic           busy,
  input logic           limit_fail,
  input logic           suspended,
  input logic [TRW-1:0] tries
);

  // R9: a parked erase never reports busy
  p_park_not_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && suspended));

  // R3: the failure state keeps busy high
  p_fail_is_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    limit_fail |-> busy);

  // R3: only reset_cmd leaves the failure state
  p_fail_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    limit_fail && !reset_cmd |=> limit_fail);

  // R3: leaving failure lands in idle
  p_fail_exit_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(limit_fail) |-> !busy && !suspended);

  // R3: iteration count never passes its limit
  p_tries_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tries < TRW'(MAX_TRIES));

  // R2: idle without a command stays idle
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && !suspended && !cmd_valid |=> !busy);

  // R10: suspension lasts until resume_req
  p_park_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    suspended && !resume_req |=> suspended);

endmodule

bind epe_sequencer epe_sequencer_checker #(.MAX_TRIES(MAX_TRIES), .TRW(TRW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .resume_req(resume_req),
  .reset_cmd(reset_cmd), .busy(busy), .limit_fail(limit_fail),
  .suspended(suspended), .tries(tries_q)
);

// File: tb/epe_sequencer_bench.sv
module epe_sequencer_bench;

  localparam int NS = 4, SB = 8, P = 3, E = 5, MT = 3, STEP = 4;
  localparam int NB = NS * SB;
  localparam int AW = 5;
  localparam int PROG_OK   = P + 1;
  localparam int PROG_BAD  = MT * (P + 1);
  localparam int PER_SEC   = SB * (P + 1) + 2 * E + 1 + SB;

  typedef struct packed {
    logic [4:0] a;
    logic [7:0] d;
    logic       f;
    logic [7:0] r;
  } vec_t;

  localparam vec_t VT [8] = '{
    '{a: 5'd3,  d: 8'hA5, f: 1'b0, r: 8'hA5},
    '{a: 5'd3,  d: 8'h25, f: 1'b0, r: 8'h25},
    '{a: 5'd3,  d: 8'hFF, f: 1'b1, r: 8'h25},
    '{a: 5'd9,  d: 8'h00, f: 1'b0, r: 8'h00},
    '{a: 5'd17, d: 8'h5A, f: 1'b0, r: 8'h5A},
    '{a: 5'd31, d: 8'hC3, f: 1'b0, r: 8'hC3},
    '{a: 5'd17, d: 8'h5B, f: 1'b1, r: 8'h5A},
    '{a: 5'd0,  d: 8'h80, f: 1'b0, r: 8'h80}
  };

  logic          clk, rst_n;
  logic          cmd_valid, suspend_req, resume_req, reset_cmd;
  logic [1:0]    cmd_op;
  logic [AW-1:0] cmd_addr, rd_addr;
  logic [7:0]    cmd_data, rd_data;
  logic [NS-1:0] cmd_sectors;
  logic          busy, limit_fail, suspended;

  int total, bad, cyc;
  bit finished;

  epe_sequencer #(
    .NSEC(NS), .SEC_BYTES(SB), .PROG_CYCLES(P), .ERASE_CYCLES(E),
    .MAX_TRIES(MT), .ERASE_STEP(STEP)
  ) u_epe_sequencer (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_sectors(cmd_sectors),
    .suspend_req(suspend_req), .resume_req(resume_req), .reset_cmd(reset_cmd),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy),
    .limit_fail(limit_fail), .suspended(suspended)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000 && !finished) begin
      total++;  bad++;
      $display("FAIL watchdog actual=%0d expected=<20000 cycles", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic rd(input int a, output int v);
    rd_addr = AW'(a);
    #1;
    v = int'(rd_data);
  endtask

  // counts bytes in [lo,hi] whose value differs from val
  task automatic count_off(input int lo, input int hi, input int val, output int n);
    int v;
    n = 0;
    for (int i = lo; i <= hi; i++) begin
      rd(i, v);
      if (v != val) n++;
    end
  endtask

  task automatic issue(input logic [1:0] op, input int a, input int d, input logic [NS-1:0] m);
    @(negedge clk);
    cmd_valid = 1'b1;  cmd_op = op;  cmd_addr = AW'(a);
    cmd_data = 8'(d);  cmd_sectors = m;
    @(negedge clk);
    cmd_valid = 1'b0;  cmd_op = 2'b00;
  endtask

  task automatic pulse_reset_cmd();
    @(negedge clk);  reset_cmd = 1'b1;
    @(negedge clk);  reset_cmd = 1'b0;
  endtask

  task automatic do_resume();
    @(negedge clk);  resume_req = 1'b1;
    @(negedge clk);  resume_req = 1'b0;
  endtask

  // busy cycles until busy drops or limit_fail rises; optional suspend pulse
  task automatic count_busy(input int susp_at, output int n);
    n = 0;
    while (busy && !limit_fail && n < 5000) begin
      n++;
      if (n == susp_at) suspend_req = 1'b1;
      @(negedge clk);
      suspend_req = 1'b0;
    end
  endtask

  initial begin
    int n, n1, n2, v;
    total = 0;  bad = 0;  cyc = 0;  finished = 1'b0;
    rst_n = 1'b0;  cmd_valid = 1'b0;  cmd_op = 2'b00;  cmd_addr = '0;
    cmd_data = '0;  cmd_sectors = '0;  suspend_req = 1'b0;  resume_req = 1'b0;
    reset_cmd = 1'b0;  rd_addr = '0;

    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 busy in reset", int'(busy), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 limit_fail", int'(limit_fail), 0);
    chk("R1 suspended", int'(suspended), 0);
    count_off(0, NB - 1, 8'hFF, n);
    chk("R1 array erased", n, 0);

    // R2 / R3: program vectors
    for (int k = 0; k < 8; k++) begin
      issue(2'b01, int'(VT[k].a), int'(VT[k].d), '0);
      count_busy(0, n);
      chk(VT[k].f ? "R3 cycles to limit" : "R2 program cycles", n, VT[k].f ? PROG_BAD : PROG_OK);
      chk("R3 limit_fail flag", int'(limit_fail), int'(VT[k].f));
      if (VT[k].f) begin
        chk("R3 busy held on fail", int'(busy), 1);
        pulse_reset_cmd();
        chk("R3 reset_cmd clears busy", int'(busy), 0);
        chk("R3 reset_cmd clears flag", int'(limit_fail), 0);
      end
      rd(int'(VT[k].a), v);
      chk(VT[k].f ? "R3 byte after fail" : "R2 byte AND", v, int'(VT[k].r));
    end

    // R4: command during a program is ignored
    issue(2'b01, 5, 8'h11, '0);
    cmd_valid = 1'b1;  cmd_op = 2'b01;  cmd_addr = AW'(6);  cmd_data = 8'h22;
    @(negedge clk);
    cmd_valid = 1'b0;  cmd_op = 2'b00;
    count_busy(0, n);
    rd(6, v);  chk("R4 busy command ignored", v, 8'hFF);
    rd(5, v);  chk("R2 first program done", v, 8'h11);

    // R4: command during the failure state is ignored
    issue(2'b01, 5, 8'hFF, '0);
    count_busy(0, n);
    issue(2'b01, 6, 8'h00, '0);
    repeat (10) @(negedge clk);
    chk("R3 limit_fail held", int'(limit_fail), 1);
    pulse_reset_cmd();
    rd(6, v);  chk("R4 fail command ignored", v, 8'hFF);

    // R8: empty sector mask
    issue(2'b11, 0, 0, 4'b0000);
    chk("R8 empty mask ignored", int'(busy), 0);

    // R5 / R6: one sector (sector 2, bytes 16..23)
    issue(2'b11, 0, 0, 4'b0100);
    count_busy(0, n);
    chk("R6 one-sector cycles", n, PER_SEC);
    count_off(16, 23, 8'hFF, n);
    chk("R5 sector 2 erased", n, 0);
    rd(31, v);  chk("R5 sector 3 untouched", v, 8'hC3);
    rd(9, v);   chk("R5 sector 1 untouched", v, 8'h00);
    rd(3, v);   chk("R5 sector 0 untouched", v, 8'h25);

    // R5 / R6: sectors 0 and 2
    issue(2'b11, 0, 0, 4'b0101);
    count_busy(0, n);
    chk("R6 two-sector cycles", n, 2 * PER_SEC);
    count_off(0, 7, 8'hFF, n);
    chk("R5 sector 0 erased", n, 0);
    rd(9, v);   chk("R5 sector 1 kept", v, 8'h00);
    rd(31, v);  chk("R5 sector 3 kept", v, 8'hC3);

    // R9 / R10: suspend a two-sector erase of sectors 1 and 3
    issue(2'b11, 0, 0, 4'b1010);
    count_busy(70, n1);
    chk("R9 suspended flag", int'(suspended), 1);
    chk("R9 busy released", int'(busy), 0);
    chk("R9 stopped early", int'(n1 < 2 * PER_SEC), 1);
    rd(4, v);  chk("R11 read while suspended", v, 8'hFF);
    issue(2'b01, 2, 8'h00, '0);
    chk("R10 program ignored while suspended", int'(suspended), 1);
    rd(2, v);  chk("R10 byte untouched while suspended", v, 8'hFF);
    do_resume();
    count_busy(0, n2);
    chk("R10 cycles before plus after", n1 + n2, 2 * PER_SEC);
    chk("R10 suspended cleared", int'(suspended), 0);
    count_off(8, 15, 8'hFF, n);
    chk("R10 sector 1 erased", n, 0);
    count_off(24, 31, 8'hFF, n);
    chk("R10 sector 3 erased", n, 0);

    // R9: suspend ignored during a program
    issue(2'b01, 2, 8'h00, '0);
    count_busy(2, n);
    chk("R9 program ignores suspend", n, PROG_OK);
    chk("R9 no suspend after program", int'(suspended), 0);

    // R7 / R9: chip erase ignores mask and suspend
    issue(2'b01, 20, 8'h3C, '0);
    count_busy(0, n);
    issue(2'b10, 0, 0, 4'b0000);
    count_busy(50, n);
    chk("R7 chip erase cycles", n, NS * PER_SEC);
    chk("R9 chip erase not suspended", int'(suspended), 0);
    count_off(0, NB - 1, 8'hFF, n);
    chk("R7 whole array erased", n, 0);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule